// File: doc/BRIEF.md
# Pass-Through / Bus-Mode Entry Sequencer

This block decides whether the bus master is in its power-up pass-through state or in its active single-wire mode. In pass-through, the host enable, busy and select signals are wired straight to the downstream port, and no bus time slot may run. The block watches each slot command. A command is the falling edge of the active-low enable input, and the two select inputs are sampled on that edge. The block counts an unbroken run of mode-toggle commands and moves between the two modes when the run reaches its length.

Leaving pass-through needs two things: the full toggle run, and a quiet interval after it in which the enable input stays high. Going back to pass-through happens at the last toggle of the run, with no quiet interval.

While in pass-through, a watchdog watches the downstream enable. If the downstream enable stays low for too long, the watchdog opens the enable pass gate, so that a stuck downstream device cannot lock the host out. The gate closes again when bus mode is entered or on reset. The bus-mode flag gates the time slot engine. The gate enable drives the enable pass switch, which is modelled here as a control level only.

Top module: `xparent_mode_seq`

## Requirements
- R1: After a synchronous reset, `bus_mode` is 0 (pass-through) and `en_pass_on` is 1.
- R2: A command is a clock edge at which `en_in_n` is sampled 0 after being sampled 1. It is a mode toggle when `bit_sel`=0 and `line_rst_n`=0 at that edge. Fewer than `RUN_LEN` consecutive toggles never change the mode.
- R3: A command with any other select combination clears the toggle count. The combinations are read/write-one (`bit_sel`=1, `line_rst_n`=1), write-zero (0,1) and line reset (1,0). The count is cleared in either mode.
- R4: After the `RUN_LEN`-th toggle in pass-through, `bus_mode` rises at the `QUIET_CYCLES`-th consecutive edge at which `en_in_n` is sampled 1, and not earlier.
- R5: A command during that quiet interval cancels entry. The mode stays pass-through and the toggle count restarts from zero, so the cancelling command is not counted.
- R6: In bus mode, the `RUN_LEN`-th consecutive toggle clears `bus_mode` at the same edge that samples its falling enable, with no quiet interval.
- R7: In pass-through, `en_pass_on` drops after `en_out_n` is sampled 0 on `WDOG_CYCLES`+1 consecutive edges. `WDOG_CYCLES` low edges are not enough, and any edge sampled high restarts the window.
- R8: Once dropped, `en_pass_on` stays 0 until bus mode is entered. It returns to 1 at the edge where `bus_mode` rises, or on reset.
- R9: In bus mode, `en_out_n` has no effect: `en_pass_on` stays 1 however long it is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_in_n | input | 1 | Host enable, active low; its falling edge issues a command |
| bit_sel | input | 1 | Slot data/clock select, sampled with the command |
| line_rst_n | input | 1 | Line-reset request, active low, sampled with the command |
| en_out_n | input | 1 | Downstream enable level seen by the watchdog |
| bus_mode | output | 1 | 1 = single-wire bus mode, 0 = pass-through |
| en_pass_on | output | 1 | Enable pass-gate control, 1 = connected |

## Verification
The bench builds the block with `QUIET_CYCLES`=8, `WDOG_CYCLES`=6 and `RUN_LEN`=4. The millisecond intervals then shrink to a handful of edges. This puts both boundaries of each interval within reach of a short run: seven against eight quiet edges, and six against seven low edges of the downstream enable. It also leaves time for toggle runs broken by each of the three other command types, for a cancel in mid-wait, and for a full round trip in and out of bus mode.

// File: rtl/xparent_mode_pkg.sv
package xparent_mode_pkg;

  typedef enum logic [1:0] {
    ST_PASS = 2'd0,
    ST_WAIT = 2'd1,
    ST_BUS  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/xm_cmd_detect.sv
module xm_cmd_detect (
  input  logic clk,
  input  logic rst,
  input  logic en_in_n,
  input  logic bit_sel,
  input  logic line_rst_n,
  output logic cmd_fire,
  output logic cmd_toggle
);

  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b1;
    else     en_q <= en_in_n;
  end

  assign cmd_fire   = en_q & ~en_in_n;
  assign cmd_toggle = cmd_fire & ~bit_sel & ~line_rst_n;

  // R2: a command is a single-edge event
  p_fire_single_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_fire |=> !cmd_fire);

endmodule

// File: rtl/xm_toggle_run.sv
module xm_toggle_run #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic cmd_fire,
  input  logic cmd_toggle,
  output logic run_done
);

  localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (cmd_fire) begin
      if (cmd_toggle && cnt != LAST) cnt <= cnt + 1'b1;
      else                           cnt <= '0;
    end
  end

  assign run_done = cmd_fire & cmd_toggle & ~clear & (cnt == LAST);

  // R2: count never passes the run length
  p_count_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R3: a non-toggle command leaves the count at zero
  p_other_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_fire && !cmd_toggle) |=> cnt == '0);

endmodule

// File: rtl/xm_quiet_timer.sv
module xm_quiet_timer #(
  parameter int QUIET_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic en_in_n,
  output logic expired
);

  localparam int TW = (QUIET_CYCLES > 1) ? $clog2(QUIET_CYCLES) : 1;
  localparam logic [TW-1:0] TLAST = TW'(QUIET_CYCLES - 1);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst || !arm || !en_in_n) tmr <= '0;
    else if (tmr == TLAST)        tmr <= '0;
    else                          tmr <= tmr + 1'b1;
  end

  assign expired = arm & en_in_n & (tmr == TLAST);

  // R4: timer stays inside its window
  p_tmr_range_r4: assert property (@(posedge clk) disable iff (rst)
    tmr <= TLAST);

  // R4: a low enable restarts the quiet interval
  p_low_restarts_r4: assert property (@(posedge clk) disable iff (rst)
    !en_in_n |=> tmr == '0);

endmodule

// File: rtl/xm_eno_watchdog.sv
module xm_eno_watchdog #(
  parameter int WDOG_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic en_out_n,
  input  logic restore,
  output logic pass_on
);

  localparam int WW = $clog2(WDOG_CYCLES + 1);
  localparam logic [WW-1:0] LIM = WW'(WDOG_CYCLES);

  logic [WW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      pass_on <= 1'b1;
    end else begin
      if (!active || en_out_n) low_cnt <= '0;
      else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;

      if (restore)                                   pass_on <= 1'b1;
      else if (active && !en_out_n && low_cnt == LIM) pass_on <= 1'b0;
    end
  end

  // R7: the gate only opens after a low downstream enable in pass-through
  p_cut_needs_low_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(pass_on) && !$past(rst)) |-> $past(!en_out_n && active));

  // R8: once open, the gate only closes on restore
  p_cut_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(pass_on) && !$past(rst)) |-> $past(restore));

endmodule

// File: rtl/xparent_mode_seq.sv
module xparent_mode_seq
  import xparent_mode_pkg::*;
#(
  parameter int RUN_LEN      = 4,
  parameter int QUIET_CYCLES = 500000,
  parameter int WDOG_CYCLES  = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_in_n,
  input  logic bit_sel,
  input  logic line_rst_n,
  input  logic en_out_n,
  output logic bus_mode,
  output logic en_pass_on
);

  seq_state_e state_q, state_d;
  logic cmd_fire, cmd_toggle, run_done, quiet_done, enter_bus;

  xm_cmd_detect u_cmd (
    .clk(clk), .rst(rst), .en_in_n(en_in_n), .bit_sel(bit_sel),
    .line_rst_n(line_rst_n), .cmd_fire(cmd_fire), .cmd_toggle(cmd_toggle)
  );

  xm_toggle_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst(rst), .clear(state_q == ST_WAIT),
    .cmd_fire(cmd_fire), .cmd_toggle(cmd_toggle), .run_done(run_done)
  );

  xm_quiet_timer #(.QUIET_CYCLES(QUIET_CYCLES)) u_quiet (
    .clk(clk), .rst(rst), .arm(state_q == ST_WAIT),
    .en_in_n(en_in_n), .expired(quiet_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PASS: if (run_done) state_d = ST_WAIT;
      ST_WAIT: begin
        if (cmd_fire)        state_d = ST_PASS;
        else if (quiet_done) state_d = ST_BUS;
      end
      ST_BUS:  if (run_done) state_d = ST_PASS;
      default: state_d = ST_PASS;
    endcase
  end

  assign enter_bus = (state_q == ST_WAIT) && (state_d == ST_BUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_PASS;
      bus_mode <= 1'b0;
    end else begin
      state_q  <= state_d;
      bus_mode <= (state_d == ST_BUS);
    end
  end

  xm_eno_watchdog #(.WDOG_CYCLES(WDOG_CYCLES)) u_wdog (
    .clk(clk), .rst(rst), .active(state_q != ST_BUS),
    .en_out_n(en_out_n), .restore(enter_bus), .pass_on(en_pass_on)
  );

  // R1: reset lands in pass-through with the gate connected
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!bus_mode && en_pass_on));

  // R4: bus mode is entered only on an edge with the enable high
  p_entry_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_mode) && !$past(rst)) |-> $past(en_in_n));

  // R6: bus mode is left only on a toggle command edge
  p_exit_on_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_mode) && !$past(rst)) |-> $past(!en_in_n && !bit_sel && !line_rst_n));

  // R9: gate stays connected throughout bus mode
  p_bus_gate_on_r9: assert property (@(posedge clk) disable iff (rst)
    bus_mode |-> en_pass_on);

endmodule

// File: tb/xparent_mode_seq_bench.sv
module xparent_mode_seq_bench;

  localparam int QUIET = 8;
  localparam int WD    = 6;

  localparam logic [1:0] OP_CMD = 2'd0, OP_IDLE = 2'd1, OP_ENOLOW = 2'd2;
  localparam logic [7:0] A_TG = 8'd0, A_RD = 8'd3, A_W0 = 8'd1, A_RS = 8'd2;

  // {op, arg, expected bus_mode, expected en_pass_on, requirement}
  localparam int NV = 52;
  localparam logic [15:0] VEC [NV] = '{
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd2},    // R2
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd2},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd2},
    {OP_CMD, A_RD, 1'b0, 1'b1, 4'd3},    // R3 read breaks run
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd3},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd3},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd3},
    {OP_CMD, A_W0, 1'b0, 1'b1, 4'd3},    // R3 write-zero breaks run
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd3},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd3},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd3},
    {OP_CMD, A_RS, 1'b0, 1'b1, 4'd3},    // R3 line reset breaks run
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd2},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd2},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd2},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd2},    // 4th toggle: wait begins
    {OP_IDLE, 8'd6, 1'b0, 1'b1, 4'd4},   // R4 7 quiet edges
    {OP_IDLE, 8'd1, 1'b1, 1'b1, 4'd4},   // R4 8th quiet edge
    {OP_ENOLOW, 8'd20, 1'b1, 1'b1, 4'd9},// R9
    {OP_CMD, A_TG, 1'b1, 1'b1, 4'd6},
    {OP_CMD, A_TG, 1'b1, 1'b1, 4'd6},
    {OP_CMD, A_TG, 1'b1, 1'b1, 4'd6},
    {OP_CMD, A_RD, 1'b1, 1'b1, 4'd3},    // R3 in bus mode
    {OP_CMD, A_TG, 1'b1, 1'b1, 4'd6},
    {OP_CMD, A_TG, 1'b1, 1'b1, 4'd6},
    {OP_CMD, A_TG, 1'b1, 1'b1, 4'd6},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd6},    // R6 exit
    {OP_ENOLOW, 8'd6, 1'b0, 1'b1, 4'd7}, // R7 not enough
    {OP_ENOLOW, 8'd7, 1'b0, 1'b0, 4'd7}, // R7 cut
    {OP_IDLE, 8'd3, 1'b0, 1'b0, 4'd8},   // R8 sticky
    {OP_CMD, A_TG, 1'b0, 1'b0, 4'd8},
    {OP_CMD, A_TG, 1'b0, 1'b0, 4'd8},
    {OP_CMD, A_TG, 1'b0, 1'b0, 4'd8},
    {OP_CMD, A_TG, 1'b0, 1'b0, 4'd8},
    {OP_IDLE, 8'd7, 1'b1, 1'b1, 4'd8},   // R8 restored on entry
    {OP_CMD, A_TG, 1'b1, 1'b1, 4'd6},
    {OP_CMD, A_TG, 1'b1, 1'b1, 4'd6},
    {OP_CMD, A_TG, 1'b1, 1'b1, 4'd6},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd6},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd2},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd2},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd2},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd2},
    {OP_IDLE, 8'd3, 1'b0, 1'b1, 4'd4},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd5},    // R5 cancel
    {OP_IDLE, 8'd10, 1'b0, 1'b1, 4'd5},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd5},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd5},
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd5},
    {OP_IDLE, 8'd10, 1'b0, 1'b1, 4'd5},  // R5 cancel not counted
    {OP_CMD, A_TG, 1'b0, 1'b1, 4'd5},
    {OP_IDLE, 8'd7, 1'b1, 1'b1, 4'd5}
  };

  logic clk = 1'b0;
  logic rst, en_in_n, bit_sel, line_rst_n, en_out_n;
  logic bus_mode, en_pass_on;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  xparent_mode_seq #(.RUN_LEN(4), .QUIET_CYCLES(QUIET), .WDOG_CYCLES(WD))
    u_xparent_mode_seq (
      .clk(clk), .rst(rst), .en_in_n(en_in_n), .bit_sel(bit_sel),
      .line_rst_n(line_rst_n), .en_out_n(en_out_n),
      .bus_mode(bus_mode), .en_pass_on(en_pass_on)
    );

  task automatic check(input int req, input logic got_m, input logic exp_m,
                       input logic got_p, input logic exp_p);
    n_checks++;
    if (got_m !== exp_m || got_p !== exp_p) begin
      n_errors++;
      $display("FAIL R%0d: bus_mode=%b exp %b, en_pass_on=%b exp %b at %0t",
               req, got_m, exp_m, got_p, exp_p, $time);
    end
  endtask

  task automatic issue(input logic [1:0] sel);
    bit_sel = sel[1]; line_rst_n = sel[0]; en_in_n = 1'b0;
    @(negedge clk);
    en_in_n = 1'b1; bit_sel = 1'b1; line_rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; en_in_n = 1'b1; bit_sel = 1'b1; line_rst_n = 1'b1; en_out_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1, bus_mode, 1'b0, en_pass_on, 1'b1);  // R1 state under reset
    rst = 1'b0;
    @(negedge clk);
    check(1, bus_mode, 1'b0, en_pass_on, 1'b1);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][15:14])
        OP_CMD:  issue(VEC[i][7:6] == 2'b00 ? 2'b00 : VEC[i][13:12] == 2'b00 ? VEC[i][7:6] : VEC[i][7:6]);
        OP_IDLE: idle(int'(VEC[i][13:6]));
        default: begin
          en_out_n = 1'b0;
          idle(int'(VEC[i][13:6]));
        end
      endcase
      check(int'(VEC[i][3:0]), bus_mode, VEC[i][5], en_pass_on, VEC[i][4]);
      if (VEC[i][15:14] == OP_ENOLOW) begin
        en_out_n = 1'b1;
        @(negedge clk);
      end
    end

    // R6: exit happens at the edge of the fourth falling enable
    for (int k = 0; k < 3; k++) issue(2'b00);
    bit_sel = 1'b0; line_rst_n = 1'b0; en_in_n = 1'b0;
    @(negedge clk);
    check(6, bus_mode, 1'b0, en_pass_on, 1'b1);
    en_in_n = 1'b1; bit_sel = 1'b1; line_rst_n = 1'b1;
    @(negedge clk);

    // R7: a high sample restarts the watchdog window
    en_out_n = 1'b0; idle(WD);
    en_out_n = 1'b1; idle(1);
    en_out_n = 1'b0; idle(WD);
    check(7, bus_mode, 1'b0, en_pass_on, 1'b1);
    idle(1);
    check(7, bus_mode, 1'b0, en_pass_on, 1'b0);
    en_out_n = 1'b1;

    // R8: reset closes the gate again
    rst = 1'b1; idle(2);
    check(8, bus_mode, 1'b0, en_pass_on, 1'b1);
    rst = 1'b0; idle(1);

    // R1: reset from bus mode returns to pass-through
    for (int k = 0; k < 4; k++) issue(2'b00);
    idle(QUIET - 1);
    check(4, bus_mode, 1'b1, en_pass_on, 1'b1);
    rst = 1'b1; idle(1);
    check(1, bus_mode, 1'b0, en_pass_on, 1'b1);
    rst = 1'b0; idle(1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule